// File: doc/BRIEF.md
# Error Event Matched Filter Bank

This block sits in the correction stage that follows a sequence detector in a storage read channel. Each sample of a frame brings three things: the equalized sample, the bit the detector decided, and a mask that says which error event types may start at that sample. From these the block forms an error signal. The error signal is the equalized sample minus the detected bits, mapped to +1/-1 and convolved with the channel target 1 + 6D + 7D^2 + 2D^3. The block correlates that error signal with the target-filtered shape of each dominant error event.

For every event type it keeps the best energy-normalized score over the permitted start positions and remembers where that score occurred. A correction stage further on uses these per-type (score, position) pairs to pick and apply an event. The bank scores every type in parallel as the samples stream in, and it needs no buffer of the whole frame.

When the frame's last sample arrives, the block runs a short internal flush of zero error samples. This lets events that start near the end of the frame be scored against a window padded with zeros. After the flush, the results are presented for one cycle. They stay on the outputs until the next frame begins.

Top module: `evmf_bank`

## Requirements
- R1: For sample k, with detected symbol s = +1 for bit 1 and s = -1 for bit 0, the error sample is e_k = q_k - (1*s_k + 6*s_{k-1} + 7*s_{k-2} + 2*s_{k-3}). Symbols before the first sample of the frame count as 0. The result saturates to a signed EW-bit value.
- R2: Event type j (0-based) is the alternating sequence +2, -2, +2, ... of length j+1. Its shape h_j is that sequence convolved with the target, which gives j+4 coefficients. The score of type j at start i is sum over m of e_{i+m}*h_j[m] minus K_j, where K_j is half of sum h_j[m]^2. Error samples past the end of the frame count as 0.
- R3: Start position i is a candidate for type j only when bit j of in_allow was 1 on the cycle that sample i was accepted.
- R4: For each type, the result is the largest candidate score. A later position replaces the current best only if its score is strictly greater, so the earliest position wins a tie. Positions are the 0-based index of the start sample within the frame.
- R5: A type with no candidate reports found = 0, the most negative SW-bit score, and position 0.
- R6: A score outside the signed SW-bit range saturates to the nearest limit.
- R7: res_valid is high for exactly one cycle. It rises on the (NEV+3)-th rising edge after the edge that captured the sample marked in_last. A frame may be a single sample long.
- R8: The block ignores a sample when in_valid is low. While idle, it also ignores a sample that does not carry in_first. While it is flushing or presenting a result, it ignores every input. Results hold until the first sample of the next frame is accepted.
- R9: After reset, res_valid and every found bit are 0, every score is the most negative value, and every position is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A sample is offered this cycle |
| in_first | input | 1 | The offered sample opens a frame |
| in_last | input | 1 | The offered sample closes the frame |
| in_bit | input | 1 | Detected bit for the sample |
| in_q | input | QW | Equalized sample, signed |
| in_allow | input | NEV | Bit j permits type j to start at this sample |
| res_valid | output | 1 | One-cycle result strobe |
| res_found | output | NEV | Bit j set when type j had at least one candidate |
| res_score | output | NEV*SW | Best score per type, signed, type j at bits j*SW upward |
| res_pos | output | NEV*PW | Start position of the best score per type, type j at bits j*PW upward |

## Verification
Any fault in the delay lines, in the alignment of the allow mask, or in the per-type offsets shows up as a score or a position that differs from the arithmetic reference. That difference appears on the very next result strobe, which comes NEV+3 cycles after the frame's last sample. A fault in the flush counter shows up as a strobe that comes too early or too late, or that lasts more than one cycle. A lost tail window shows up as a wrong result for an event injected at the last positions of a frame. If the error history fails to clear between frames, the scores at the first three positions of the next frame go wrong. If the result registers fail to hold, the outputs differ on the cycle after the strobe.

// File: rtl/evmf_pkg.sv
package evmf_pkg;

   // channel target taps, coefficient of D^l at index l
   localparam int TAPS = 4;
   localparam int GTAP [TAPS] = '{1, 6, 7, 2};

   typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FLUSH} evmf_state_e;

   // amplitude of an alternating error event of length len at index n
   function automatic int ev_amp(int len, int n);
      if (n < 0 || n >= len) return 0;
      return (n % 2 == 0) ? 2 : -2;
   endfunction

   // coefficient m of the event convolved with the target
   function automatic int shape(int len, int m);
      int acc;
      acc = 0;
      for (int l = 0; l < TAPS; l++) acc += GTAP[l] * ev_amp(len, m - l);
      return acc;
   endfunction

   // half of the filtered-event energy
   function automatic longint half_energy(int len);
      longint acc;
      acc = 0;
      for (int m = 0; m < len + TAPS - 1; m++)
         acc += longint'(shape(len, m)) * longint'(shape(len, m));
      return acc / 2;
   endfunction

   function automatic longint sat(longint v, int w);
      longint hi, lo;
      hi = (longint'(1) <<< (w - 1)) - 64'sd1;
      lo = -hi - 64'sd1;
      if (v > hi) return hi;
      if (v < lo) return lo;
      return v;
   endfunction

endpackage

// File: rtl/evmf_err_former.sv
module evmf_err_former
   import evmf_pkg::*;
#(
   parameter int QW = 8,
   parameter int EW = 10
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 take,
   input  logic                 first,
   input  logic                 bit_in,
   input  logic signed [QW-1:0] q,
   output logic signed [EW-1:0] e
);

   // previous detected symbols, index 0 newest; 0 means before the frame
   logic signed [1:0] hist [TAPS-1];

   always_comb begin
      longint acc;
      acc = longint'(q);
      acc -= longint'(GTAP[0]) * (bit_in ? 64'sd1 : -64'sd1);
      for (int l = 1; l < TAPS; l++)
         acc -= longint'(GTAP[l]) * (first ? 64'sd0 : longint'(hist[l-1]));
      e = EW'(sat(acc, EW));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < TAPS - 1; i++) hist[i] <= '0;
      end else if (take) begin
         hist[0] <= bit_in ? 2'b01 : 2'b11;
         for (int i = 1; i < TAPS - 1; i++) hist[i] <= first ? 2'b00 : hist[i-1];
      end
   end

endmodule

// File: rtl/evmf_scorer.sv
module evmf_scorer
   import evmf_pkg::*;
#(
   parameter int LEN = 1,
   parameter int EW  = 10,
   parameter int SW  = 20,
   parameter int PW  = 9,
   localparam int LH = LEN + TAPS - 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clear,
   input  logic                 eval,
   input  logic                 allowed,
   input  logic [PW-1:0]        start_pos,
   input  logic [LH*EW-1:0]     win,
   output logic signed [SW-1:0] best_score,
   output logic [PW-1:0]        best_pos,
   output logic                 found
);

   localparam longint KJ = half_energy(LEN);
   localparam logic signed [SW-1:0] SMIN = {1'b1, {(SW-1){1'b0}}};

   logic signed [63:0] prod [LH];
   logic signed [SW-1:0] cand;

   for (genvar m = 0; m < LH; m++) begin : g_tap
      localparam int HM = shape(LEN, m);
      assign prod[m] = longint'($signed(win[m*EW +: EW])) * longint'(HM);
   end

   always_comb begin
      longint acc;
      acc = 0;
      for (int m = 0; m < LH; m++) acc += prod[m];
      cand = SW'(sat(acc - KJ, SW));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         best_score <= SMIN;
         best_pos   <= '0;
         found      <= 1'b0;
      end else if (clear) begin
         best_score <= SMIN;
         best_pos   <= '0;
         found      <= 1'b0;
      end else if (eval && allowed && (!found || cand > best_score)) begin
         best_score <= cand;
         best_pos   <= start_pos;
         found      <= 1'b1;
      end
   end

endmodule

// File: rtl/evmf_bank.sv
module evmf_bank
   import evmf_pkg::*;
#(
   parameter int QW      = 8,
   parameter int EW      = 10,
   parameter int SW      = 20,
   parameter int NEV     = 6,
   parameter int MAX_LEN = 256,
   localparam int LHMAX  = NEV + TAPS - 1,
   localparam int PW     = $clog2(MAX_LEN + LHMAX),
   localparam int FCW    = $clog2(LHMAX)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic                 in_first,
   input  logic                 in_last,
   input  logic                 in_bit,
   input  logic signed [QW-1:0] in_q,
   input  logic [NEV-1:0]       in_allow,
   output logic                 res_valid,
   output logic [NEV-1:0]       res_found,
   output logic [NEV*SW-1:0]    res_score,
   output logic [NEV*PW-1:0]    res_pos
);

   if (NEV < 1 || NEV > 8) begin : g_bad_nev
      $error("evmf_bank: NEV must lie in 1..8");
   end
   if (EW < QW) begin : g_bad_ew
      $error("evmf_bank: EW must be at least QW");
   end
   if (SW < EW + 2) begin : g_bad_sw
      $error("evmf_bank: SW too narrow");
   end
   if (MAX_LEN < 1) begin : g_bad_len
      $error("evmf_bank: MAX_LEN must be positive");
   end

   evmf_state_e          state;
   logic [FCW-1:0]       fcnt;
   logic                 fin_q, eval_q;
   logic [PW-1:0]        pos0;
   logic                 start_w, take_w, shift_w, idle_w;
   logic signed [EW-1:0] e_w;
   logic signed [EW-1:0] ew [LHMAX];
   logic [NEV-1:0]       aw [LHMAX];

   assign idle_w  = (state == ST_IDLE);
   assign start_w = in_valid && in_first && idle_w && !fin_q;
   assign take_w  = start_w || (in_valid && state == ST_RUN);
   assign shift_w = take_w || (state == ST_FLUSH);

   evmf_err_former #(.QW(QW), .EW(EW)) u_former (
      .clk    (clk),
      .rst_n  (rst_n),
      .take   (take_w),
      .first  (start_w),
      .bit_in (in_bit),
      .q      (in_q),
      .e      (e_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         fcnt      <= '0;
         fin_q     <= 1'b0;
         eval_q    <= 1'b0;
         res_valid <= 1'b0;
         pos0      <= '0;
      end else begin
         eval_q    <= shift_w;
         res_valid <= fin_q;
         fin_q     <= (state == ST_FLUSH) && (fcnt == FCW'(LHMAX - 2));
         if (shift_w) pos0 <= start_w ? '0 : pos0 + 1'b1;
         case (state)
            ST_IDLE: if (start_w) begin
               fcnt  <= '0;
               state <= in_last ? ST_FLUSH : ST_RUN;
            end
            ST_RUN: if (take_w && in_last) begin
               fcnt  <= '0;
               state <= ST_FLUSH;
            end
            ST_FLUSH: begin
               fcnt <= fcnt + 1'b1;
               if (fcnt == FCW'(LHMAX - 2)) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // error and allow delay lines, index 0 holds the newest sample
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < LHMAX; i++) begin
            ew[i] <= '0;
            aw[i] <= '0;
         end
      end else if (shift_w) begin
         ew[0] <= take_w ? e_w : '0;
         aw[0] <= take_w ? in_allow : '0;
         for (int i = 1; i < LHMAX; i++) begin
            ew[i] <= ew[i-1];
            aw[i] <= start_w ? '0 : aw[i-1];
         end
      end
   end

   for (genvar j = 0; j < NEV; j++) begin : g_ev
      localparam int LH = j + TAPS;
      logic [LH*EW-1:0]     wv;
      logic signed [SW-1:0] sc;
      logic [PW-1:0]        ps;
      logic                 fd;

      for (genvar m = 0; m < LH; m++) begin : g_win
         assign wv[m*EW +: EW] = ew[LH-1-m];
      end

      evmf_scorer #(.LEN(j + 1), .EW(EW), .SW(SW), .PW(PW)) u_scorer (
         .clk        (clk),
         .rst_n      (rst_n),
         .clear      (start_w),
         .eval       (eval_q),
         .allowed    (aw[LH-1][j]),
         .start_pos  (pos0 - PW'(LH - 1)),
         .win        (wv),
         .best_score (sc),
         .best_pos   (ps),
         .found      (fd)
      );

      assign res_score[j*SW +: SW] = sc;
      assign res_pos[j*PW +: PW]   = ps;
      assign res_found[j]          = fd;
   end

endmodule

// File: rtl/evmf_bank_chk.sv
module evmf_bank_chk #(
   parameter int NEV     = 6,
   parameter int SW      = 20,
   parameter int PW      = 9,
   parameter int MAX_LEN = 256
) (
   input logic              clk,
   input logic              rst_n,
   input logic              res_valid,
   input logic [NEV-1:0]    res_found,
   input logic [NEV*SW-1:0] res_score,
   input logic [NEV*PW-1:0] res_pos,
   input logic              idle_now,
   input logic              fin_pend,
   input logic              in_valid,
   input logic              in_first
);

   logic empty_bad, pos_bad;

   always_comb begin
      empty_bad = 1'b0;
      pos_bad   = 1'b0;
      for (int j = 0; j < NEV; j++) begin
         if (!res_found[j] && (res_score[j*SW +: SW] != {1'b1, {(SW-1){1'b0}}}
                               || res_pos[j*PW +: PW] != '0))
            empty_bad = 1'b1;
         if (res_found[j] && res_pos[j*PW +: PW] >= PW'(MAX_LEN))
            pos_bad = 1'b1;
      end
   end

   assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   assert_empty_type_R5: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> !empty_bad);

   assert_pos_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> !pos_bad);

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_now && !fin_pend && !res_valid && !(in_valid && in_first))
      |=> ($stable(res_score) && $stable(res_pos) && $stable(res_found)));

endmodule

bind evmf_bank evmf_bank_chk #(
   .NEV(NEV), .SW(SW), .PW(PW), .MAX_LEN(MAX_LEN)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .res_valid (res_valid),
   .res_found (res_found),
   .res_score (res_score),
   .res_pos   (res_pos),
   .idle_now  (idle_w),
   .fin_pend  (fin_q),
   .in_valid  (in_valid),
   .in_first  (in_first)
);

// File: tb/evmf_bank_bench.sv
module evmf_bank_bench;

   localparam int QW = 8, EW = 8, SW = 12, NEV = 6, MAX_LEN = 64;
   localparam int LHMAX = NEV + 3;
   localparam int PW = $clog2(MAX_LEN + LHMAX);
   localparam int G [4] = '{1, 6, 7, 2};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic                 in_valid = 0, in_first = 0, in_last = 0, in_bit = 0;
   logic signed [QW-1:0] in_q = '0;
   logic [NEV-1:0]       in_allow = '0;
   logic                 res_valid;
   logic [NEV-1:0]       res_found;
   logic [NEV*SW-1:0]    res_score;
   logic [NEV*PW-1:0]    res_pos;

   evmf_bank #(.QW(QW), .EW(EW), .SW(SW), .NEV(NEV), .MAX_LEN(MAX_LEN)) u_evmf_bank (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
      .in_last(in_last), .in_bit(in_bit), .in_q(in_q), .in_allow(in_allow),
      .res_valid(res_valid), .res_found(res_found), .res_score(res_score),
      .res_pos(res_pos)
   );

   int n_cmp = 0, n_bad = 0;
   bit finished = 0;
   int unsigned seed = 32'h2545_f491;
   int qv [MAX_LEN];
   bit bv [MAX_LEN];
   logic [NEV-1:0] av [MAX_LEN];

   function automatic int unsigned rnd();
      seed ^= seed << 13;
      seed ^= seed >> 17;
      seed ^= seed << 5;
      return seed;
   endfunction

   function automatic longint satw(longint v, int w);
      longint hi;
      hi = (longint'(1) <<< (w - 1)) - 1;
      if (v > hi) return hi;
      if (v < -hi - 1) return -hi - 1;
      return v;
   endfunction

   function automatic int amp(int len, int n);
      if (n < 0 || n >= len) return 0;
      return (n % 2 == 0) ? 2 : -2;
   endfunction

   function automatic int hh(int len, int m);
      int s;
      s = 0;
      for (int l = 0; l < 4; l++) s += G[l] * amp(len, m - l);
      return s;
   endfunction

   task automatic check(string tag, string what, longint act, longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic build(int n, int mode, int ilen, int ipos);
      for (int k = 0; k < n; k++) bv[k] = (rnd() & 1) != 0;
      for (int k = 0; k < n; k++) begin
         int ideal;
         ideal = 0;
         for (int l = 0; l < 4; l++)
            if (k - l >= 0) ideal += G[l] * (bv[k-l] ? 1 : -1);
         case (mode)
            2, 4:    qv[k] = ideal;
            3:       qv[k] = ((rnd() & 1) != 0) ? 127 : -128;
            default: qv[k] = int'(rnd() % 256) - 128;
         endcase
         case (mode)
            1:       av[k] = '0;
            2, 3:    av[k] = '1;
            default: av[k] = NEV'(rnd());
         endcase
      end
      if (mode == 4) begin
         for (int m = 0; m < ilen + 3; m++)
            if (ipos + m < n) qv[ipos+m] += hh(ilen, m);
         av[ipos] = '1;
      end
   endtask

   task automatic compare(int n, string tag);
      longint ee [MAX_LEN + LHMAX];
      for (int k = 0; k < MAX_LEN + LHMAX; k++) begin
         longint acc;
         acc = 0;
         if (k < n) begin
            acc = qv[k];
            for (int l = 0; l < 4; l++)
               if (k - l >= 0) acc -= G[l] * (bv[k-l] ? 1 : -1);
            acc = satw(acc, EW);
         end
         ee[k] = acc;
      end
      for (int j = 0; j < NEV; j++) begin
         longint kj, best, sc;
         int bpos, lh;
         bit fnd;
         lh = j + 4;
         kj = 0;
         for (int m = 0; m < lh; m++) kj += hh(j + 1, m) * hh(j + 1, m);
         kj = kj / 2;
         best = -(longint'(1) <<< (SW - 1));
         bpos = 0;
         fnd = 0;
         for (int i = 0; i < n; i++) begin
            if (av[i][j]) begin
               longint acc;
               acc = 0;
               for (int m = 0; m < lh; m++) acc += ee[i+m] * hh(j + 1, m);
               sc = satw(acc - kj, SW);
               if (!fnd || sc > best) begin
                  best = sc;
                  bpos = i;
                  fnd = 1;
               end
            end
         end
         check(tag, $sformatf("type %0d score", j),
               longint'($signed(res_score[j*SW +: SW])), best);
         check(tag, $sformatf("type %0d position", j),
               longint'(res_pos[j*PW +: PW]), bpos);
         check(tag, $sformatf("type %0d found", j), longint'(res_found[j]), fnd);
      end
   endtask

   task automatic run_frame(int n, int mode, int ilen, int ipos, string tag);
      int waited;
      build(n, mode, ilen, ipos);
      // offered without in_first while idle: must be ignored (R8)
      in_valid = 1; in_first = 0; in_last = 1; in_bit = 1; in_q = 8'sd100; in_allow = '1;
      @(negedge clk);
      for (int k = 0; k < n; k++) begin
         if (rnd() % 5 == 0) begin
            in_valid = 0; in_first = 1; in_q = QW'(rnd()); in_allow = '1; in_bit = 1;
            @(negedge clk);
         end
         in_valid = 1; in_first = (k == 0); in_last = (k == n - 1);
         in_bit = bv[k]; in_q = QW'(qv[k]); in_allow = av[k];
         @(negedge clk);
      end
      waited = 1;
      while (!res_valid && waited < 40) begin
         in_valid = (rnd() & 1) != 0; in_first = 0; in_last = (rnd() & 1) != 0;
         in_bit = (rnd() & 1) != 0; in_q = QW'(rnd()); in_allow = NEV'(rnd());
         @(negedge clk);
         waited++;
      end
      in_valid = 0; in_first = 0; in_last = 0;
      check("R7", "result latency in cycles", waited, LHMAX + 1);
      compare(n, tag);
      @(negedge clk);
      check("R7", "strobe width", longint'(res_valid), 0);
      compare(n, "R8");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R9", "res_valid after reset", longint'(res_valid), 0);
      check("R9", "found after reset", longint'(res_found), 0);
      for (int j = 0; j < NEV; j++) begin
         check("R9", "score after reset", longint'($signed(res_score[j*SW +: SW])),
               -(longint'(1) <<< (SW - 1)));
         check("R9", "position after reset", longint'(res_pos[j*PW +: PW]), 0);
      end
      run_frame(1, 0, 1, 0, "R7");
      run_frame(1, 3, 1, 0, "R1_R6");
      run_frame(MAX_LEN, 0, 1, 0, "R3");
      run_frame(20, 1, 1, 0, "R5");
      run_frame(30, 2, 1, 0, "R4");
      run_frame(25, 3, 1, 0, "R1_R6");
      run_frame(MAX_LEN, 3, 1, 0, "R6");
      for (int j = 1; j <= NEV; j++) begin
         run_frame(40, 4, j, 3 + 5 * j, "R2");
         run_frame(40, 4, j, 39, "R2");
         run_frame(12, 4, j, 0, "R2");
      end
      for (int f = 0; f < 20; f++)
         run_frame(1 + int'(rnd() % MAX_LEN), 0, 1, 0, "R3");
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule